// File: doc/BRIEF.md
# Soft-Start and Fault Supervisor

This block sequences a phase-shifted full-bridge controller. It decides when the four bridge drivers may switch, and it limits how much phase shift the loop may command while the converter ramps up or winds down. It reads digitised samples of the supply, the reference rail, the current sense, the error-amplifier output and the level on the external soft-start/disable node. From these it produces a drive enable, a cycle-by-cycle cut request, the clamped duty/phase limit, the internal soft-start level and the sequencer state.

The soft-start level is an up/down counter. It climbs by a base step every `TICK_DIV` clocks and falls ten times faster. An overcurrent does not latch the bridge off. It starts a controlled wind-down, and when that is finished a full soft start follows. Undervoltage and light-load detection both use hysteresis. All thresholds are parameters in sample codes.

Top module: `ssf_supervisor`

## Requirements
- R1: During and after reset the state is LOCKOUT (code 0), and `drive_en`, `ss_level` and `duty_lim` are all 0.
- R2: An undervoltage flag is set when `vdd_smp < UV_OFF` and cleared when `vdd_smp > UV_ON`. Between the two thresholds it holds its value, and it is set out of reset. While the flag is set or `ref_smp < REF_OK`, the state goes to LOCKOUT at the next edge from any state, with `ss_level` 0 at that same edge.
- R3: When not locked out, a `dis_smp` below `DIS_TH` moves the state to DISABLED (code 4) at the next edge with `ss_level` 0. Releasing it moves the state to SOFT_START (code 1).
- R4: In SOFT_START, `ss_level` starts at 0 and rises by `STEP` every `TICK_DIV` clocks, saturating at `RAMP_MAX`. The state becomes RUN (code 2) one edge after `ss_level` reaches `RAMP_MAX`.
- R5: `cs_smp >= OC_TH` in SOFT_START or RUN moves the state to SOFT_STOP (code 3) at the next edge. In SOFT_STOP, `ss_level` falls by `10*STEP` every `TICK_DIV` clocks, with a floor of 0.
- R6: SOFT_STOP ends when `ss_level < DIS_TH`, and the state becomes SOFT_START at the next edge.
- R7: Outside RUN, `duty_lim` equals the smaller of `ea_smp` and `ss_level`. In RUN it equals `ea_smp`.
- R8: `drive_en` is 0 in the same cycle that an overcurrent, a low reference or a low disable level is present. It is also 0 in every state other than SOFT_START and RUN.
- R9: A light-load flag is set when `ea_smp < NL_OFF` and cleared when `ea_smp > NL_ON`. It is updated at each edge and is set out of reset. While it is set, `drive_en` is 0.
- R10: `cycle_cut` equals `drive_en && cs_smp >= PK_TH`. A reading with `PK_TH <= cs_smp < OC_TH` leaves the state unchanged.
- R11: An overcurrent during SOFT_STOP neither restarts nor lengthens the wind-down. If the overcurrent is still present after the return to SOFT_START, the state goes back to SOFT_STOP at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_smp | input | W | Supply voltage sample |
| ref_smp | input | W | Reference rail sample |
| cs_smp | input | W | Current-sense sample |
| ea_smp | input | W | Error-amplifier output sample |
| dis_smp | input | W | Soft-start/disable node sample |
| drive_en | output | 1 | Bridge drivers may switch |
| cycle_cut | output | 1 | End the present on-interval (peak limit) |
| duty_lim | output | W | Clamped duty/phase command |
| ss_level | output | W | Soft-start level |
| state_o | output | 3 | Sequencer state code |

## Verification
The supply is swept up and then down through the undervoltage band, one code at a time. This separates the two thresholds from each other and shows that the flag holds between them. The error command changes every cycle during a complete ramp-up, so the clamp is compared against a moving soft-start level, and the exact ramp-up length confirms the rate and saturation. The current-sense input is stepped across the peak and overcurrent thresholds. The overcurrent is held through the whole wind-down, which exposes the rate of descent, the end condition and re-entry. The error command is walked back and forth around the light-load band, and the reference and disable inputs are dropped from active states to show that the drive is removed at once and the level is cleared.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
   typedef enum logic [2:0] {
      SV_LOCKOUT   = 3'd0,
      SV_SOFTSTART = 3'd1,
      SV_RUN       = 3'd2,
      SV_SOFTSTOP  = 3'd3,
      SV_DISABLED  = 3'd4
   } ssf_state_e;
endpackage

// File: rtl/ssf_hyst.sv
// Two-threshold detector: flag sets below LO, clears above HI, holds between.
module ssf_hyst #(
   parameter int W    = 11,
   parameter int LO   = 900,
   parameter int HI   = 1100,
   parameter bit INIT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] x,
   output logic         flag
);
   localparam logic [W-1:0] LO_C = W'(LO);
   localparam logic [W-1:0] HI_C = W'(HI);

   if (LO > HI) begin : g_bad_band
      $error("ssf_hyst: LO must not exceed HI");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag <= INIT;
      else if (x < LO_C)  flag <= 1'b1;
      else if (x > HI_C)  flag <= 1'b0;
   end

   // R2, R9
   hyst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (x < LO_C) |=> flag);
   // R2, R9
   hyst_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (x > HI_C) |=> !flag);
endmodule

// File: rtl/ssf_ramp.sv
// Soft-start level: up by STEP, down by 10*STEP, once per TICK_DIV clocks.
module ssf_ramp #(
   parameter int W        = 11,
   parameter int MAX      = 500,
   parameter int STEP     = 1,
   parameter int TICK_DIV = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         up,
   input  logic         dn,
   output logic [W-1:0] level
);
   localparam int       DSTEP = 10 * STEP;
   localparam logic [W:0] MAX_X = (W+1)'(MAX);
   localparam logic [W:0] UP_X  = (W+1)'(STEP);
   localparam logic [W:0] DN_X  = (W+1)'(DSTEP);

   if (MAX >= (1 << W) || STEP < 1 || TICK_DIV < 1) begin : g_bad_cfg
      $error("ssf_ramp: MAX must fit W, STEP and TICK_DIV must be positive");
   end

   logic         tick;
   logic         moving;
   logic [W:0]   wide;
   logic [W-1:0] nxt;

   assign moving = (up | dn) & ~clr;
   assign wide   = {1'b0, level};

   if (TICK_DIV <= 1) begin : g_every
      assign tick = moving;
   end else begin : g_div
      localparam int CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           cnt <= '0;
         else if (!moving)     cnt <= '0;
         else if (cnt == LAST) cnt <= '0;
         else                  cnt <= cnt + 1'b1;
      end
      assign tick = moving && (cnt == LAST);
   end

   always_comb begin
      nxt = level;
      if (clr)
         nxt = '0;
      else if (tick && dn)
         nxt = (wide > DN_X) ? W'(wide - DN_X) : '0;
      else if (tick && up)
         nxt = ((wide + UP_X) >= MAX_X) ? W'(MAX_X) : W'(wide + UP_X);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level <= '0;
      else        level <= nxt;
   end

   // R4
   ramp_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, level} <= MAX_X);
   // R4
   ramp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up && !dn && !clr) |=> (level >= $past(level)));
   // R5
   ramp_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn && !clr) |=> (level <= $past(level)));
   // R2
   ramp_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (level == '0));
endmodule

// File: rtl/ssf_supervisor.sv
module ssf_supervisor
   import ssf_pkg::*;
#(
   parameter int W        = 11,
   parameter int UV_ON    = 1100,
   parameter int UV_OFF   = 900,
   parameter int REF_OK   = 400,
   parameter int DIS_TH   = 50,
   parameter int OC_TH    = 250,
   parameter int PK_TH    = 200,
   parameter int NL_OFF   = 50,
   parameter int NL_ON    = 60,
   parameter int RAMP_MAX = 500,
   parameter int STEP     = 1,
   parameter int TICK_DIV = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] vdd_smp,
   input  logic [W-1:0] ref_smp,
   input  logic [W-1:0] cs_smp,
   input  logic [W-1:0] ea_smp,
   input  logic [W-1:0] dis_smp,
   output logic         drive_en,
   output logic         cycle_cut,
   output logic [W-1:0] duty_lim,
   output logic [W-1:0] ss_level,
   output logic [2:0]   state_o
);
   localparam logic [W-1:0] REF_C = W'(REF_OK);
   localparam logic [W-1:0] DIS_C = W'(DIS_TH);
   localparam logic [W-1:0] OC_C  = W'(OC_TH);
   localparam logic [W-1:0] PK_C  = W'(PK_TH);
   localparam logic [W-1:0] MAX_C = W'(RAMP_MAX);

   if (PK_TH >= OC_TH) begin : g_bad_cs
      $error("ssf_supervisor: peak threshold must sit below overcurrent");
   end
   if (DIS_TH >= RAMP_MAX) begin : g_bad_ramp
      $error("ssf_supervisor: ramp ceiling must exceed disable level");
   end

   ssf_state_e state, state_nx;
   logic uv_low, nl_low;
   logic lock_cond, dis_now, oc_now, pk_now;
   logic ramp_clr, ramp_up, ramp_dn;

   ssf_hyst #(.W(W), .LO(UV_OFF), .HI(UV_ON), .INIT(1'b1)) u_uv (
      .clk(clk), .rst_n(rst_n), .x(vdd_smp), .flag(uv_low));

   ssf_hyst #(.W(W), .LO(NL_OFF), .HI(NL_ON), .INIT(1'b1)) u_nl (
      .clk(clk), .rst_n(rst_n), .x(ea_smp), .flag(nl_low));

   assign lock_cond = uv_low || (ref_smp < REF_C);
   assign dis_now   = dis_smp < DIS_C;
   assign oc_now    = cs_smp >= OC_C;
   assign pk_now    = cs_smp >= PK_C;

   always_comb begin
      state_nx = state;
      if (lock_cond) begin
         state_nx = SV_LOCKOUT;
      end else begin
         unique case (state)
            SV_LOCKOUT:   state_nx = SV_SOFTSTART;
            SV_DISABLED:  if (!dis_now) state_nx = SV_SOFTSTART;
            SV_SOFTSTART: if (dis_now)                  state_nx = SV_DISABLED;
                          else if (oc_now)              state_nx = SV_SOFTSTOP;
                          else if (ss_level == MAX_C)   state_nx = SV_RUN;
            SV_RUN:       if (dis_now)                  state_nx = SV_DISABLED;
                          else if (oc_now)              state_nx = SV_SOFTSTOP;
            SV_SOFTSTOP:  if (dis_now)                  state_nx = SV_DISABLED;
                          else if (ss_level < DIS_C)    state_nx = SV_SOFTSTART;
            default:      state_nx = SV_LOCKOUT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SV_LOCKOUT;
      else        state <= state_nx;
   end

   assign ramp_clr = lock_cond || dis_now || (state == SV_LOCKOUT) ||
                     (state == SV_DISABLED);
   assign ramp_up  = (state == SV_SOFTSTART);
   assign ramp_dn  = (state == SV_SOFTSTOP);

   ssf_ramp #(.W(W), .MAX(RAMP_MAX), .STEP(STEP), .TICK_DIV(TICK_DIV)) u_ramp (
      .clk(clk), .rst_n(rst_n), .clr(ramp_clr), .up(ramp_up), .dn(ramp_dn),
      .level(ss_level));

   assign drive_en  = ((state == SV_SOFTSTART) || (state == SV_RUN)) &&
                      !lock_cond && !dis_now && !oc_now && !nl_low;
   assign cycle_cut = drive_en && pk_now;
   assign duty_lim  = (state == SV_RUN || ea_smp < ss_level) ? ea_smp : ss_level;
   assign state_o   = state;

   // R2
   lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_cond |=> (state == SV_LOCKOUT) && (ss_level == '0));
   // R3
   disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_cond && dis_now && state != SV_LOCKOUT) |=>
         (state == SV_DISABLED) && (ss_level == '0));
   // R5
   oc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_cond && !dis_now && oc_now &&
       (state == SV_RUN || state == SV_SOFTSTART)) |=> (state == SV_SOFTSTOP));
   // R4
   run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SV_RUN && $past(state) != SV_RUN) |-> ($past(ss_level) == MAX_C));
endmodule

// File: tb/ssf_supervisor_tb_top.sv
module ssf_supervisor_tb_top;
   localparam int W = 8;
   localparam int UV_ON = 110, UV_OFF = 90, REF_OK = 40, DIS_TH = 5;
   localparam int OC_TH = 25, PK_TH = 20, NL_OFF = 5, NL_ON = 6;
   localparam int RMAX = 40, STEP = 1, TDIV = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] vdd = 8'd100, refv = 8'd50, cs = 8'd0, ea = 8'd30, dis = 8'd50;
   logic drive_en, cycle_cut;
   logic [W-1:0] duty_lim, ss_level;
   logic [2:0] state_o;
   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   ssf_supervisor #(.W(W), .UV_ON(UV_ON), .UV_OFF(UV_OFF), .REF_OK(REF_OK),
      .DIS_TH(DIS_TH), .OC_TH(OC_TH), .PK_TH(PK_TH), .NL_OFF(NL_OFF),
      .NL_ON(NL_ON), .RAMP_MAX(RMAX), .STEP(STEP), .TICK_DIV(TDIV)) dut_i (
      .clk(clk), .rst_n(rst_n), .vdd_smp(vdd), .ref_smp(refv), .cs_smp(cs),
      .ea_smp(ea), .dis_smp(dis), .drive_en(drive_en), .cycle_cut(cycle_cut),
      .duty_lim(duty_lim), .ss_level(ss_level), .state_o(state_o));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_state(input int code, input int limit);
      for (int i = 0; i < limit && int'(state_o) != code; i++) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit uvm;
      int n;
      int nl_m;
      int exp_ss;
      int nl_seq [8] = '{5, 4, 5, 6, 7, 6, 5, 4};
      repeat (3) @(negedge clk);
      // R1 reset values
      chk(state_o == 3'd0 && !drive_en && ss_level == 0 && duty_lim == 0,
          "R1 reset", int'(state_o), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R2 in band after reset stays locked out
      chk(state_o == 3'd0, "R2 band after reset", int'(state_o), 0);

      // R2 hysteresis sweep up then down
      uvm = 1'b1;
      for (int pass = 0; pass < 2; pass++) begin
         for (int k = 0; k <= 40; k++) begin
            int v;
            v = (pass == 0) ? 80 + k : 120 - k;
            vdd = W'(v);
            if (v < UV_OFF) uvm = 1'b1;
            else if (v > UV_ON) uvm = 1'b0;
            repeat (3) @(negedge clk);
            chk((state_o == 3'd0) == uvm, "R2 uv sweep", int'(state_o), uvm ? 0 : 1);
         end
      end

      // R4 / R7 full ramp-up with a moving error command
      vdd = 8'd80; repeat (4) @(negedge clk);
      vdd = 8'd120;
      wait_state(1, 10);
      n = 0;
      while (n < 100) begin
         exp_ss = (n / TDIV) * STEP;
         if (exp_ss > RMAX) exp_ss = RMAX;
         if (n <= RMAX * TDIV) begin
            chk(state_o == 3'd1 && int'(ss_level) == exp_ss, "R4 ramp level",
                int'(ss_level), exp_ss);
            ea = W'((n * 7) % 64);
            #1;
            chk(int'(duty_lim) == ((int'(ea) < exp_ss) ? int'(ea) : exp_ss),
                "R7 clamp", int'(duty_lim), (int'(ea) < exp_ss) ? int'(ea) : exp_ss);
         end else begin
            break;
         end
         @(negedge clk);
         n++;
      end
      chk(state_o == 3'd2 && n == RMAX * TDIV + 1, "R4 run entry", n, RMAX * TDIV + 1);

      // R7 unclamped in run
      ea = 8'd60; @(negedge clk); @(negedge clk);
      chk(duty_lim == 8'd60 && drive_en, "R7 run passthrough", int'(duty_lim), 60);

      // R9 light-load hysteresis walk
      nl_m = 0;
      for (int k = 0; k < 8; k++) begin
         ea = W'(nl_seq[k]);
         if (nl_seq[k] < NL_OFF) nl_m = 1;
         else if (nl_seq[k] > NL_ON) nl_m = 0;
         @(negedge clk);
         chk(drive_en == !nl_m, "R9 light load", int'(drive_en), !nl_m);
      end
      ea = 8'd60; @(negedge clk);

      // R10 peak limit band
      for (int c = 19; c < OC_TH; c++) begin
         cs = W'(c);
         #1;
         chk(cycle_cut == (c >= PK_TH) && drive_en, "R10 cut", int'(cycle_cut), c >= PK_TH);
         @(negedge clk);
         chk(state_o == 3'd2, "R10 no state change", int'(state_o), 2);
      end

      // R8 / R5 / R6 / R11 overcurrent held through the wind-down
      cs = 8'd25;
      #1;
      chk(!drive_en, "R8 oc immediate", int'(drive_en), 0);
      @(negedge clk);
      n = 0;
      while (n < 9) begin
         exp_ss = RMAX - 10 * STEP * (n / TDIV);
         if (exp_ss < 0) exp_ss = 0;
         chk(state_o == 3'd3 && int'(ss_level) == exp_ss, "R5 stop descent",
             int'(ss_level), exp_ss);
         chk(int'(duty_lim) == ((60 < exp_ss) ? 60 : exp_ss), "R7 stop clamp",
             int'(duty_lim), (60 < exp_ss) ? 60 : exp_ss);
         @(negedge clk);
         n++;
      end
      chk(state_o == 3'd1, "R6 stop end R11 no restart", int'(state_o), 1);
      @(negedge clk);
      chk(state_o == 3'd3, "R11 re-entry", int'(state_o), 3);
      cs = 8'd0;
      wait_state(2, 200);
      chk(state_o == 3'd2, "R6 recovered to run", int'(state_o), 2);

      // R3 / R8 external disable
      dis = 8'd3;
      #1;
      chk(!drive_en, "R8 disable immediate", int'(drive_en), 0);
      @(negedge clk);
      chk(state_o == 3'd4 && ss_level == 0, "R3 disabled", int'(state_o), 4);
      dis = 8'd50;
      @(negedge clk);
      chk(state_o == 3'd1 && ss_level == 0, "R3 release", int'(state_o), 1);

      // R2 / R8 reference drop mid ramp
      repeat (10) @(negedge clk);
      chk(ss_level == 8'd5, "R4 partial ramp", int'(ss_level), 5);
      refv = 8'd30;
      #1;
      chk(!drive_en, "R8 ref immediate", int'(drive_en), 0);
      @(negedge clk);
      chk(state_o == 3'd0 && ss_level == 0 && duty_lim == 0, "R2 ref lockout",
          int'(ss_level), 0);
      refv = 8'd50;
      @(negedge clk);
      chk(state_o == 3'd1, "R2 ref recovery", int'(state_o), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule